// File: doc/BRIEF.md
# Supply-Low Digital Reset Filter

This block takes a raw, already synchronous flag from an analog comparator that goes high whenever the supply sits below its trip threshold. It turns that flag into a clean low-supply level and an optional reset request. A short dip must not trigger anything, so the level rises only after an unbroken run of high flag samples. A single good sample clears the level at once. Recovery is therefore fast, while noise spikes are rejected.

Three configuration inputs shape the behaviour. The first powers the whole monitor. The second decides whether the filtered level also raises the reset request, or only shows up in the status byte for software to poll. The third keeps the monitor working while the device is in stop mode. A fourth input skips the filter, so the registered raw flag drives the level directly. The filtered level appears in the top bit of a read-only status byte. The reset request is a plain level, and a downstream reset controller stretches it.

Top module: `supply_guard`

## Requirements
- R1: In filter mode, `status_o[7]` goes to 1 at the clock edge that samples `low_flag_i` high for the ninth consecutive time (parameter `RUN_LEN`, default 9). After only eight consecutive high samples it is still 0.
- R2: Once the level is 1, a single edge that samples `low_flag_i` low clears both `status_o[7]` and `reset_req_o` at that edge.
- R3: The run counter restarts from zero on every low sample. It saturates at `RUN_LEN` instead of wrapping, so the level stays 1 for as long as the flag stays high.
- R4: At any edge that samples `cfg_enable_i` low, both outputs go to 0 and the run counter is cleared.
- R5: `reset_req_o` is 1 exactly when the level is 1 and `cfg_reset_en_i` was sampled 1 at the same edge. With reset enable at 0, the level drives only the status bit.
- R6: `status_o` is a read-only byte. Bit 7 is the filtered level (1 means the supply is low), and bits 6 to 0 always read 0.
- R7: While `stop_mode_i` is 1 and `cfg_stop_keep_i` is 0, the counter is cleared and both outputs go to 0. With `cfg_stop_keep_i` at 1, filtering continues as normal in stop mode.
- R8: With `cfg_bypass_i` at 1 (and the monitor active), the level equals `low_flag_i` as sampled at the previous edge, with no run required.
- R9: While `rst_n` is low, the counter, the level and the reset request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_flag_i | input | 1 | Raw comparator flag, 1 = supply below trip |
| cfg_enable_i | input | 1 | Monitor power enable |
| cfg_reset_en_i | input | 1 | Allow the level to raise the reset request |
| cfg_stop_keep_i | input | 1 | Keep the monitor active in stop mode |
| cfg_bypass_i | input | 1 | Skip the run filter |
| stop_mode_i | input | 1 | Device is in stop mode |
| status_o | output | 8 | Status byte, bit 7 = filtered low level |
| reset_req_o | output | 1 | Reset request level |

## Verification
Every cycle, the assertions check the following:
- a rise of the level is backed by a full run of high samples, counted independently of the design;
- a low sample clears the level;
- disabling the monitor, or stop mode without keep, silences both outputs;
- the request never appears without the level or while reset enable is off;
- the low status bits stay zero.

Some behaviours can only be shown by the bench scenarios:
- the exact eight-versus-nine boundary;
- the counter restarting after a broken run;
- the counter saturating over long runs;
- the counter being cleared by a disable pulse;
- the bypass timing.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // Operating mode picked from configuration and stop state
    typedef enum logic [1:0] {
        SG_OFF    = 2'd0,
        SG_FILTER = 2'd1,
        SG_DIRECT = 2'd2
    } sg_mode_e;

    typedef struct packed {
        logic req;
    } sg_top_s;

endpackage

// File: rtl/sg_mode_sel.sv
module sg_mode_sel
    import sg_pkg::*;
(
    input  logic     enable_i,
    input  logic     stop_mode_i,
    input  logic     stop_keep_i,
    input  logic     bypass_i,
    output sg_mode_e mode_o
);

    logic active;

    always_comb begin
        active = enable_i && (!stop_mode_i || stop_keep_i);
        if (!active) begin
            mode_o = SG_OFF;
        end else if (bypass_i) begin
            mode_o = SG_DIRECT;
        end else begin
            mode_o = SG_FILTER;
        end
    end

endmodule

// File: rtl/sg_run_filter.sv
module sg_run_filter
    import sg_pkg::*;
#(
    parameter int RUN_LEN = 9
) (
    input  logic     clk,
    input  logic     rst_n,
    input  sg_mode_e mode_i,
    input  logic     flag_i,
    output logic     level_d_o,
    output logic     level_q_o
);

    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          level;
    } filt_s;

    filt_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (mode_i)
            SG_FILTER: begin
                if (flag_i) begin
                    if (state_q.count != RUN_MAX) begin
                        state_d.count = state_q.count + 1'b1;
                    end
                    state_d.level = (state_d.count >= RUN_MAX);
                end else begin
                    state_d.count = '0;
                    state_d.level = 1'b0;
                end
            end
            SG_DIRECT: begin
                state_d.count = '0;
                state_d.level = flag_i;
            end
            default: begin
                state_d.count = '0;
                state_d.level = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level_d_o = state_d.level;
    assign level_q_o = state_q.level;

endmodule

// File: rtl/sg_status_fmt.sv
module sg_status_fmt #(
    parameter int STATUS_W = 8
) (
    input  logic                level_i,
    output logic [STATUS_W-1:0] status_o
);

    localparam int PAD_W = STATUS_W - 1;

    assign status_o = {level_i, {PAD_W{1'b0}}};

endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import sg_pkg::*;
#(
    parameter int RUN_LEN  = 9,
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                low_flag_i,
    input  logic                cfg_enable_i,
    input  logic                cfg_reset_en_i,
    input  logic                cfg_stop_keep_i,
    input  logic                cfg_bypass_i,
    input  logic                stop_mode_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                reset_req_o
);

    sg_mode_e mode;
    logic     level_d;
    logic     level_q;
    sg_top_s  top_d, top_q;

    sg_mode_sel u_mode (
        .enable_i    (cfg_enable_i),
        .stop_mode_i (stop_mode_i),
        .stop_keep_i (cfg_stop_keep_i),
        .bypass_i    (cfg_bypass_i),
        .mode_o      (mode)
    );

    sg_run_filter #(.RUN_LEN(RUN_LEN)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .flag_i    (low_flag_i),
        .level_d_o (level_d),
        .level_q_o (level_q)
    );

    sg_status_fmt #(.STATUS_W(STATUS_W)) u_status (
        .level_i  (level_q),
        .status_o (status_o)
    );

    always_comb begin
        top_d     = top_q;
        top_d.req = level_d && cfg_reset_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign reset_req_o = top_q.req;

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
    parameter int RUN_LEN  = 9,
    parameter int STATUS_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                low_flag_i,
    input logic                cfg_enable_i,
    input logic                cfg_reset_en_i,
    input logic                cfg_stop_keep_i,
    input logic                cfg_bypass_i,
    input logic                stop_mode_i,
    input logic [STATUS_W-1:0] status_o,
    input logic                reset_req_o
);

    int  chk_run;
    logic chk_active;

    assign chk_active = cfg_enable_i && (!stop_mode_i || cfg_stop_keep_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run <= 0;
        end else if (chk_active && !cfg_bypass_i && low_flag_i) begin
            if (chk_run < RUN_LEN) chk_run <= chk_run + 1;
        end else begin
            chk_run <= 0;
        end
    end

    // R1
    run_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_o[STATUS_W-1]) && !$past(cfg_bypass_i)) |-> (chk_run >= RUN_LEN));

    // R2
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low_flag_i |=> (!status_o[STATUS_W-1] && !reset_req_o));

    // R4
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_i |=> (!status_o[STATUS_W-1] && !reset_req_o));

    // R5
    req_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> status_o[STATUS_W-1]);

    // R5
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_reset_en_i |=> !reset_req_o);

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STATUS_W-2:0] == '0);

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode_i && !cfg_stop_keep_i) |=> (!status_o[STATUS_W-1] && !reset_req_o));

endmodule

bind supply_guard sg_checker #(.RUN_LEN(RUN_LEN), .STATUS_W(STATUS_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .low_flag_i      (low_flag_i),
    .cfg_enable_i    (cfg_enable_i),
    .cfg_reset_en_i  (cfg_reset_en_i),
    .cfg_stop_keep_i (cfg_stop_keep_i),
    .cfg_bypass_i    (cfg_bypass_i),
    .stop_mode_i     (stop_mode_i),
    .status_o        (status_o),
    .reset_req_o     (reset_req_o)
);

// File: tb/supply_guard_tb.sv
module supply_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_flag_i = 1'b0;
    logic       cfg_enable_i = 1'b1;
    logic       cfg_reset_en_i = 1'b1;
    logic       cfg_stop_keep_i = 1'b0;
    logic       cfg_bypass_i = 1'b0;
    logic       stop_mode_i = 1'b0;
    logic [7:0] status_o;
    logic       reset_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    supply_guard u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .low_flag_i      (low_flag_i),
        .cfg_enable_i    (cfg_enable_i),
        .cfg_reset_en_i  (cfg_reset_en_i),
        .cfg_stop_keep_i (cfg_stop_keep_i),
        .cfg_bypass_i    (cfg_bypass_i),
        .stop_mode_i     (stop_mode_i),
        .status_o        (status_o),
        .reset_req_o     (reset_req_o)
    );

    typedef struct packed {
        logic [4:0] reps;
        logic       flag;
        logic       en;
        logic       rsten;
        logic       keep;
        logic       byp;
        logic       stop;
        logic       lvl;
        logic       req;
        logic [3:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{5'd8,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd1}, // R1 eight highs not enough
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd1}, // R1 ninth high asserts
        '{5'd20, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd3}, // R3 saturation holds level
        '{5'd1,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2}, // R2 one low clears
        '{5'd8,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 fresh run of eight
        '{5'd1,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 break the run
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 restart from zero
        '{5'd9,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd5}, // R5 polling only
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd5}, // R5 request follows enable
        '{5'd1,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd5}, // R5 request drops with enable
        '{5'd1,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 disabled
        '{5'd8,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 counter was cleared
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd4}, // R4 ninth after re-enable
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd7}, // R7 stop without keep
        '{5'd8,  1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'd7}, // R7 stop with keep, eight
        '{5'd1,  1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1, 4'd7}, // R7 stop with keep, ninth
        '{5'd1,  1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'd7}, // R7 recovery in stop
        '{5'd1,  1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd8}, // R8 bypass asserts at once
        '{5'd1,  1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd8}, // R8 bypass release
        '{5'd1,  1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd8}, // R8 bypass, polling only
        '{5'd1,  1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd8}  // R8 bypass still needs enable
    };

    task automatic check(input string req, input logic exp_lvl, input logic exp_req);
        logic [7:0] exp_status;
        exp_status = {exp_lvl, 7'b0};
        n_checks++;
        if (status_o !== exp_status || reset_req_o !== exp_req) begin
            n_fail++;
            $display("FAIL %s: status=%02h req=%b expected status=%02h req=%b",
                     req, status_o, reset_req_o, exp_status, exp_req);
        end
    endtask

    task automatic drive(input vec_t v);
        low_flag_i      = v.flag;
        cfg_enable_i    = v.en;
        cfg_reset_en_i  = v.rsten;
        cfg_stop_keep_i = v.keep;
        cfg_bypass_i    = v.byp;
        stop_mode_i     = v.stop;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        vec_t base;
        base = '{5'd1, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd0};

        // R9 reset state with the flag high and clocks running
        low_flag_i = 1'b1;
        repeat (12) @(negedge clk);
        check("R9", 1'b0, 1'b0);
        low_flag_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", 1'b0, 1'b0);

        // Table walk: drive at the falling edge, check after the last repetition
        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i].reps); r++) begin
                drive(VEC[i]);
                @(negedge clk);
            end
            check($sformatf("R%0d row %0d", VEC[i].tag, i), VEC[i].lvl, VEC[i].req);
        end

        // R1 cycle-exact boundary, with every step checked
        drive(base);
        @(negedge clk);
        check("R2", 1'b0, 1'b0);
        for (int k = 1; k <= 9; k++) begin
            low_flag_i = 1'b1;
            @(negedge clk);
            check($sformatf("R1 step %0d", k), (k >= 9), (k >= 9));
        end

        // R9 asynchronous reset while the level is asserted
        #2 rst_n = 1'b0;
        #1 check("R9 async", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 counter restarted by reset: eight highs give nothing
        for (int k = 0; k < 8; k++) @(negedge clk);
        check("R3 after reset", 1'b0, 1'b0);
        @(negedge clk);
        check("R1 after reset", 1'b1, 1'b1);

        // R7 stop pulse clears the counter mid-run
        drive(base);
        @(negedge clk);
        low_flag_i = 1'b1;
        repeat (5) @(negedge clk);
        stop_mode_i = 1'b1;
        @(negedge clk);
        stop_mode_i = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 stop clears counter", 1'b0, 1'b0);

        finish_run();
    end

endmodule